// File: doc/BRIEF.md
# Procedure Return Address Predictor

This block predicts where a procedure return will land in an in-order pipeline. Call-side logic pushes return addresses onto a small last-in-first-out store. Each decoded single load is presented with its destination register, base register, offset kind, condition information, low address bits and the target value actually loaded. The block classifies the load and, for an unconditional return, pops the newest stored address as the prediction. It compares that prediction with the resolved target and reports the outcome.

One clock after a load is presented, the block reports four things: whether a prediction was made, the predicted address, a one-cycle mispredict pulse that the pipeline may use to start a flush, and the number of issue cycles and memory cycles the load occupies. A load counts as a return only when it writes the program counter (register 15) from an address based on the stack pointer (register 13) with an immediate offset. The register file does not tell pre-indexed from post-indexed addressing, and writeback does not matter either, so every such form is treated alike.

Top module: `ret_stack_predictor`

## Requirements
- R1: The store holds three addresses. A push into a full store drops the oldest entry, so only the three newest pushes can later be predicted, newest first.
- R2: A load is a return only if its destination is 15, its base is 13 and its offset kind is 2'b00 (immediate). A program-counter load with any other base or offset kind is not predicted.
- R3: An unconditional return that finds the store non-empty pops the newest entry. One cycle later it shows pred_valid=1 and pred_addr equal to that entry. If the target matches, it also shows mispredict=0, cycles=4 and mem_cycles=1.
- R4: If the resolved target differs from the popped entry, the block shows mispredict=1 and cycles=9 for that one cycle only. pred_addr still holds the popped entry.
- R5: A conditional return (ld_cond=1) whose condition passes is not predicted and costs cycles=8, and so is a return that finds the store empty. A conditional return leaves the store unchanged.
- R6: A program-counter load that is not a return costs cycles=8 and mem_cycles=1 for a one-issue offset kind (2'b00 or 2'b01). For a two-issue offset kind (ld_ofs_kind[1]=1) it costs cycles=9 and mem_cycles=2.
- R7: A load whose condition fails (ld_cond=1, ld_cond_pass=0) is never predicted and leaves the store unchanged. It reports cycles and mem_cycles of 1 for a one-issue kind and 2 for a two-issue kind.
- R8: A program-counter load with ld_addr_lo not equal to 0 is rejected. It shows align_err=1, pred_valid=0, cycles=0 and mem_cycles=0, and it leaves the store unchanged.
- R9: A pop from an empty store leaves it empty. A push and a predicted return in the same cycle replace the newest entry and leave the count unchanged.
- R10: A synchronous reset empties the store and clears all outputs. A cycle with no load presented shows all outputs at zero.
- R11: A load to any register other than 15 is never predicted. It reports cycles and mem_cycles of 1 for a one-issue kind and 2 for a two-issue kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Push a return address this cycle |
| push_addr | input | ADDR_W | Return address to push |
| ld_valid | input | 1 | A single load is presented this cycle |
| ld_dst | input | 4 | Destination register index |
| ld_base | input | 4 | Base register index |
| ld_ofs_kind | input | 2 | 00 immediate, 01 positive plain register, 1x two-issue register form |
| ld_cond | input | 1 | Load is conditional |
| ld_cond_pass | input | 1 | Condition evaluated true |
| ld_addr_lo | input | 2 | Low two bits of the access address |
| ld_target | input | ADDR_W | Value actually loaded |
| pred_valid | output | 1 | A prediction was made |
| pred_addr | output | ADDR_W | Predicted return address, zero when none |
| mispredict | output | 1 | Prediction differed from the loaded value |
| cycles | output | 4 | Issue cycles of the reported load, zero when none |
| mem_cycles | output | 2 | Memory cycles of the reported load |
| align_err | output | 1 | Unaligned program-counter load rejected |

## Verification
The assertions assume that rst is high from the first clock edge, so that every look back into the previous cycle sees defined load inputs. They also assume that each presented load is reported in the following cycle, whatever the next input is. The bench holds reset from time zero and changes inputs only on the falling edge. It never presents an unaligned load with a failing condition, because that combination is not covered by any rule the requirements rank.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
    localparam logic [3:0] REG_PC = 4'd15;
    localparam logic [3:0] REG_SP = 4'd13;

    localparam logic [3:0] CYC_HIT    = 4'd4;
    localparam logic [3:0] CYC_MISS   = 4'd9;
    localparam logic [3:0] CYC_BYPASS = 4'd8;
    localparam logic [3:0] CYC_JMP1   = 4'd8;
    localparam logic [3:0] CYC_JMP2   = 4'd9;

    localparam logic [1:0] OFS_IMM = 2'b00;

    typedef enum logic [2:0] {
        LC_NONE,
        LC_PLAIN,
        LC_CFAIL,
        LC_PCJMP,
        LC_RET_COND,
        LC_RET,
        LC_BADALIGN
    } ld_class_e;

    function automatic logic is_two_issue(input logic [1:0] kind);
        return kind[1];
    endfunction
endpackage

// File: rtl/rsp_classify.sv
module rsp_classify
    import rsp_pkg::*;
(
    input  logic       valid,
    input  logic [3:0] dst,
    input  logic [3:0] base,
    input  logic [1:0] kind,
    input  logic       cond,
    input  logic       pass,
    input  logic [1:0] addr_lo,
    output ld_class_e  cls,
    output logic       two_issue
);
    always_comb begin
        two_issue = is_two_issue(kind);
        if (!valid)
            cls = LC_NONE;
        else if (dst == REG_PC && addr_lo != 2'b00)
            cls = LC_BADALIGN;
        else if (cond && !pass)
            cls = LC_CFAIL;
        else if (dst != REG_PC)
            cls = LC_PLAIN;
        else if (base == REG_SP && kind == OFS_IMM)
            cls = cond ? LC_RET_COND : LC_RET;
        else
            cls = LC_PCJMP;
    end
endmodule

// File: rtl/rsp_stack.sv
module rsp_stack #(
    parameter int DEPTH  = 3,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic              top_valid,
    output logic [ADDR_W-1:0] top_addr
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] ent;
        logic [CW-1:0]                cnt;
    } stk_t;

    stk_t st_q, st_d, after_pop;

    always_comb begin
        after_pop = st_q;
        if (pop && st_q.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++)
                after_pop.ent[i] = st_q.ent[i+1];
            after_pop.ent[DEPTH-1] = '0;
            after_pop.cnt = st_q.cnt - 1'b1;
        end
        st_d = after_pop;
        if (push) begin
            for (int i = DEPTH - 1; i > 0; i--)
                st_d.ent[i] = after_pop.ent[i-1];
            st_d.ent[0] = push_addr;
            st_d.cnt = (after_pop.cnt == FULL) ? FULL : after_pop.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign top_valid = (st_q.cnt != '0);
    assign top_addr  = st_q.ent[0];
endmodule

// File: rtl/ret_stack_predictor.sv
module ret_stack_predictor
    import rsp_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              ld_valid,
    input  logic [3:0]        ld_dst,
    input  logic [3:0]        ld_base,
    input  logic [1:0]        ld_ofs_kind,
    input  logic              ld_cond,
    input  logic              ld_cond_pass,
    input  logic [1:0]        ld_addr_lo,
    input  logic [ADDR_W-1:0] ld_target,
    output logic              pred_valid,
    output logic [ADDR_W-1:0] pred_addr,
    output logic              mispredict,
    output logic [3:0]        cycles,
    output logic [1:0]        mem_cycles,
    output logic              align_err
);
    typedef struct packed {
        logic              pv;
        logic [ADDR_W-1:0] pa;
        logic              mp;
        logic [3:0]        cyc;
        logic [1:0]        mem;
        logic              err;
    } out_t;

    ld_class_e         cls;
    logic              two_issue;
    logic              top_valid;
    logic [ADDR_W-1:0] top_addr;
    logic              do_pop;
    out_t              out_d, out_q;

    rsp_classify u_cls (
        .valid     (ld_valid),
        .dst       (ld_dst),
        .base      (ld_base),
        .kind      (ld_ofs_kind),
        .cond      (ld_cond),
        .pass      (ld_cond_pass),
        .addr_lo   (ld_addr_lo),
        .cls       (cls),
        .two_issue (two_issue)
    );

    assign do_pop = (cls == LC_RET) && top_valid;

    rsp_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (push_valid),
        .push_addr (push_addr),
        .pop       (do_pop),
        .top_valid (top_valid),
        .top_addr  (top_addr)
    );

    always_comb begin
        out_d = '0;
        unique case (cls)
            LC_RET: begin
                out_d.mem = 2'd1;
                if (top_valid) begin
                    out_d.pv  = 1'b1;
                    out_d.pa  = top_addr;
                    out_d.mp  = (ld_target != top_addr);
                    out_d.cyc = out_d.mp ? CYC_MISS : CYC_HIT;
                end else begin
                    out_d.cyc = CYC_BYPASS;
                end
            end
            LC_RET_COND: begin
                out_d.cyc = CYC_BYPASS;
                out_d.mem = 2'd1;
            end
            LC_PCJMP: begin
                out_d.cyc = two_issue ? CYC_JMP2 : CYC_JMP1;
                out_d.mem = two_issue ? 2'd2 : 2'd1;
            end
            LC_PLAIN, LC_CFAIL: begin
                out_d.cyc = two_issue ? 4'd2 : 4'd1;
                out_d.mem = two_issue ? 2'd2 : 2'd1;
            end
            LC_BADALIGN: out_d.err = 1'b1;
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign pred_valid = out_q.pv;
    assign pred_addr  = out_q.pa;
    assign mispredict = out_q.mp;
    assign cycles     = out_q.cyc;
    assign mem_cycles = out_q.mem;
    assign align_err  = out_q.err;
endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_valid,
    input logic [3:0]        ld_dst,
    input logic              ld_cond,
    input logic              ld_cond_pass,
    input logic [1:0]        ld_addr_lo,
    input logic              pred_valid,
    input logic              mispredict,
    input logic [3:0]        cycles,
    input logic [1:0]        mem_cycles,
    input logic              align_err
);
    assert_hit_cost_R3: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && !mispredict) |-> (cycles == 4'd4 && mem_cycles == 2'd1));

    assert_miss_cost_R4: assert property (@(posedge clk) disable iff (rst)
        mispredict |-> (pred_valid && cycles == 4'd9));

    assert_cfail_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        $past(ld_valid && ld_cond && !ld_cond_pass && ld_addr_lo == 2'b00)
        |-> (!pred_valid && !mispredict && cycles != 4'd0 && cycles <= 4'd2));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        align_err |-> (!pred_valid && cycles == 4'd0 && mem_cycles == 2'd0));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(ld_valid) |-> (!pred_valid && !mispredict && cycles == 4'd0 && !align_err));

    assert_nonpc_R11: assert property (@(posedge clk) disable iff (rst)
        $past(ld_valid && ld_dst != 4'd15) |-> (!pred_valid && (cycles == 4'd1 || cycles == 4'd2)));
endmodule

bind ret_stack_predictor rsp_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .ld_valid     (ld_valid),
    .ld_dst       (ld_dst),
    .ld_cond      (ld_cond),
    .ld_cond_pass (ld_cond_pass),
    .ld_addr_lo   (ld_addr_lo),
    .pred_valid   (pred_valid),
    .mispredict   (mispredict),
    .cycles       (cycles),
    .mem_cycles   (mem_cycles),
    .align_err    (align_err)
);

// File: tb/ret_stack_predictor_tb_top.sv
module ret_stack_predictor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    typedef struct packed {
        logic [7:0]    req;
        logic          pv;
        logic [AW-1:0] pa;
        logic          lv;
        logic [3:0]    dst;
        logic [3:0]    base;
        logic [1:0]    kind;
        logic          cnd;
        logic          pass;
        logic [1:0]    lo;
        logic [AW-1:0] tgt;
        logic          e_pv;
        logic [AW-1:0] e_pa;
        logic          e_mp;
        logic [3:0]    e_cyc;
        logic [1:0]    e_mem;
        logic          e_err;
    } vec_t;

    function automatic vec_t V(input int req, input logic pv, input logic [AW-1:0] pa,
                               input logic lv, input int dst, input int base, input int kind,
                               input logic cnd, input logic pass, input int lo,
                               input logic [AW-1:0] tgt, input logic e_pv,
                               input logic [AW-1:0] e_pa, input logic e_mp,
                               input int e_cyc, input int e_mem, input logic e_err);
        vec_t v;
        v.req = 8'(req); v.pv = pv; v.pa = pa; v.lv = lv;
        v.dst = 4'(dst); v.base = 4'(base); v.kind = 2'(kind);
        v.cnd = cnd; v.pass = pass; v.lo = 2'(lo); v.tgt = tgt;
        v.e_pv = e_pv; v.e_pa = e_pa; v.e_mp = e_mp;
        v.e_cyc = 4'(e_cyc); v.e_mem = 2'(e_mem); v.e_err = e_err;
        return v;
    endfunction

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        V(1, 1, 'h100, 0,  0,  0, 0, 0, 0, 0, 'h0,   0, 'h0,   0, 0, 0, 0),  // R1 push
        V(1, 1, 'h200, 0,  0,  0, 0, 0, 0, 0, 'h0,   0, 'h0,   0, 0, 0, 0),  // R1 push
        V(1, 1, 'h300, 0,  0,  0, 0, 0, 0, 0, 'h0,   0, 'h0,   0, 0, 0, 0),  // R1 push (full)
        V(1, 1, 'h400, 0,  0,  0, 0, 0, 0, 0, 'h0,   0, 'h0,   0, 0, 0, 0),  // R1 drops 0x100
        V(3, 0, 'h0,   1, 15, 13, 0, 0, 0, 0, 'h400, 1, 'h400, 0, 4, 1, 0),  // R3 hit
        V(3, 0, 'h0,   1, 15, 13, 0, 0, 0, 0, 'h300, 1, 'h300, 0, 4, 1, 0),  // R3 hit
        V(4, 0, 'h0,   1, 15, 13, 0, 0, 0, 0, 'h999, 1, 'h200, 1, 9, 1, 0),  // R4 miss
        V(1, 0, 'h0,   1, 15, 13, 0, 0, 0, 0, 'h100, 0, 'h0,   0, 8, 1, 0),  // R1 oldest gone, R5 empty
        V(9, 0, 'h0,   1, 15, 13, 0, 0, 0, 0, 'h100, 0, 'h0,   0, 8, 1, 0),  // R9 empty stays empty
        V(3, 1, 'h500, 0,  0,  0, 0, 0, 0, 0, 'h0,   0, 'h0,   0, 0, 0, 0),  // push
        V(5, 0, 'h0,   1, 15, 13, 0, 1, 1, 0, 'h500, 0, 'h0,   0, 8, 1, 0),  // R5 conditional bypass
        V(7, 0, 'h0,   1, 15, 13, 0, 1, 0, 0, 'h500, 0, 'h0,   0, 1, 1, 0),  // R7 cond fail one-issue
        V(2, 0, 'h0,   1, 15, 13, 1, 0, 0, 0, 'h500, 0, 'h0,   0, 8, 1, 0),  // R2 register offset
        V(2, 0, 'h0,   1, 15,  4, 0, 0, 0, 0, 'h500, 0, 'h0,   0, 8, 1, 0),  // R2 other base
        V(6, 0, 'h0,   1, 15,  4, 2, 0, 0, 0, 'h500, 0, 'h0,   0, 9, 2, 0),  // R6 two-issue
        V(7, 0, 'h0,   1, 15,  4, 3, 1, 0, 0, 'h500, 0, 'h0,   0, 2, 2, 0),  // R7 cond fail two-issue
        V(8, 0, 'h0,   1, 15, 13, 0, 0, 0, 2, 'h500, 0, 'h0,   0, 0, 0, 1),  // R8 unaligned
        V(11,0, 'h0,   1,  3, 13, 0, 0, 0, 0, 'h500, 0, 'h0,   0, 1, 1, 0),  // R11 one-issue
        V(11,0, 'h0,   1,  3,  5, 2, 0, 0, 1, 'h500, 0, 'h0,   0, 2, 2, 0),  // R11 two-issue
        V(5, 0, 'h0,   1, 15, 13, 0, 0, 0, 0, 'h500, 1, 'h500, 0, 4, 1, 0),  // R5/R7/R8 stack untouched
        V(9, 1, 'h600, 0,  0,  0, 0, 0, 0, 0, 'h0,   0, 'h0,   0, 0, 0, 0),  // push
        V(9, 1, 'h700, 1, 15, 13, 0, 0, 0, 0, 'h600, 1, 'h600, 0, 4, 1, 0),  // R9 push+pop
        V(9, 0, 'h0,   1, 15, 13, 0, 0, 0, 0, 'h700, 1, 'h700, 0, 4, 1, 0),  // R9 top replaced
        V(9, 0, 'h0,   1, 15, 13, 0, 0, 0, 0, 'h700, 0, 'h0,   0, 8, 1, 0)   // R9 count unchanged
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_valid = 1'b0;
    logic [AW-1:0] push_addr = '0;
    logic          ld_valid = 1'b0;
    logic [3:0]    ld_dst = '0;
    logic [3:0]    ld_base = '0;
    logic [1:0]    ld_ofs_kind = '0;
    logic          ld_cond = 1'b0;
    logic          ld_cond_pass = 1'b0;
    logic [1:0]    ld_addr_lo = '0;
    logic [AW-1:0] ld_target = '0;
    logic          pred_valid;
    logic [AW-1:0] pred_addr;
    logic          mispredict;
    logic [3:0]    cycles;
    logic [1:0]    mem_cycles;
    logic          align_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ret_stack_predictor #(.DEPTH(3), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_addr(push_addr),
        .ld_valid(ld_valid), .ld_dst(ld_dst), .ld_base(ld_base),
        .ld_ofs_kind(ld_ofs_kind), .ld_cond(ld_cond), .ld_cond_pass(ld_cond_pass),
        .ld_addr_lo(ld_addr_lo), .ld_target(ld_target),
        .pred_valid(pred_valid), .pred_addr(pred_addr), .mispredict(mispredict),
        .cycles(cycles), .mem_cycles(mem_cycles), .align_err(align_err)
    );

    task automatic apply(input vec_t v);
        @(negedge clk);
        push_valid = v.pv; push_addr = v.pa; ld_valid = v.lv;
        ld_dst = v.dst; ld_base = v.base; ld_ofs_kind = v.kind;
        ld_cond = v.cnd; ld_cond_pass = v.pass; ld_addr_lo = v.lo; ld_target = v.tgt;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input int idx, input vec_t v);
        checks++;
        if (pred_valid !== v.e_pv || pred_addr !== v.e_pa || mispredict !== v.e_mp ||
            cycles !== v.e_cyc || mem_cycles !== v.e_mem || align_err !== v.e_err) begin
            failures++;
            $display("FAIL R%0d step %0d: got pv=%0b pa=%h mp=%0b cyc=%0d mem=%0d err=%0b, expected pv=%0b pa=%h mp=%0b cyc=%0d mem=%0d err=%0b",
                     v.req, idx, pred_valid, pred_addr, mispredict, cycles, mem_cycles, align_err,
                     v.e_pv, v.e_pa, v.e_mp, v.e_cyc, v.e_mem, v.e_err);
        end
    endtask

    initial begin
        vec_t idle;
        idle = V(10, 0, 'h0, 0, 0, 0, 0, 0, 0, 0, 'h0, 0, 'h0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #1;
        expect_out(-1, idle);  // R10 reset state
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            expect_out(i, VECS[i]);
        end

        // R10: reset mid-run empties the stack
        apply(V(10, 1, 'h800, 0, 0, 0, 0, 0, 0, 0, 'h0, 0, 'h0, 0, 0, 0, 0));
        @(negedge clk);
        rst = 1'b1;
        ld_valid = 1'b1; ld_dst = 4'd15; ld_base = 4'd13; ld_ofs_kind = 2'd0;
        push_valid = 1'b0;
        @(posedge clk);
        #1;
        expect_out(100, idle);  // R10 outputs cleared under reset
        @(negedge clk);
        rst = 1'b0;
        apply(V(10, 0, 'h0, 1, 15, 13, 0, 0, 0, 0, 'h800, 0, 'h0, 0, 8, 1, 0));
        expect_out(101, V(10, 0, 'h0, 1, 15, 13, 0, 0, 0, 0, 'h800, 0, 'h0, 0, 8, 1, 0));
        apply(idle);
        expect_out(102, idle);  // R10 idle cycle all zero

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule